// File: doc/BRIEF.md
# Ethernet Transmit Framer with Early Start

The block turns a frame that a host writes into a byte buffer into an Ethernet frame on a byte-wide output stream. The host first hands over a per-frame command. The command gives the frame length, a start threshold, a pad enable and a CRC enable. The host then writes its bytes (destination address, source address, length/type and payload) into the buffer. Bytes may also be written before the command arrives.

Once enough bytes are buffered, the framer sends a preamble and start-of-frame delimiter. It then forwards the host bytes unchanged, adds zero padding if padding is enabled and the frame is short, and appends an IEEE 802.3 CRC-32 if CRC is enabled. Early start lets the output begin while the host is still writing. If the host falls behind, the buffer can run dry before the frame is complete. The framer then abandons the frame and flags an underrun.

The output never stalls. While a frame is in progress, one byte is presented every cycle, and a done pulse follows the end of every frame.

Top module: `tx_framer`

## Requirements
- R1: After reset, `tx_valid`, `tx_last`, `tx_done` and `tx_underrun` are low, and `cmd_ready` is high.
- R2: `cmd_start_sel` picks the start threshold: 0 selects 5 bytes, 1 selects 381, 2 selects 1021, and 3 selects the whole frame. A threshold larger than `cmd_len` is cut to `cmd_len`. No output byte appears before that many host bytes have been accepted into the buffer.
- R3: Each frame opens with seven 0x55 bytes followed by one 0xD5 byte.
- R4: After the delimiter, the `cmd_len` host bytes appear unchanged and in the order they were written.
- R5: With padding enabled, a frame body shorter than the minimum is extended with 0x00 bytes. The minimum is 60 bytes when CRC is enabled and 64 bytes when it is not. With padding disabled, no pad byte is added.
- R6: With CRC enabled, four bytes follow the body. They hold the complement of the CRC-32 (polynomial 0x04C11DB7, register preset to all ones) over the body bytes including pad. They are sent least significant byte first, with bits in reflected order.
- R7: With CRC disabled, the frame ends with the last body byte.
- R8: If the buffer is empty when the next host byte is due, the framer emits nothing further for that frame and gives no last flag. It pulses `tx_underrun` together with `tx_done` and returns to idle.
- R9: The bytes of a frame appear on consecutive cycles with `tx_valid` high. `tx_last` is high only on the final byte. `tx_done` pulses for one cycle, on the cycle after that byte.
- R10: A command is taken only while `cmd_ready` is high, which is between frames. A `cmd_valid` pulse during a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_start_sel | input | 2 | Start threshold select (0:5, 1:381, 2:1021, 3:whole) |
| cmd_pad_en | input | 1 | Pad short frames |
| cmd_crc_en | input | 1 | Append CRC-32 |
| cmd_len | input | LEN_W | Number of host bytes in the frame |
| cmd_ready | output | 1 | Framer idle, command accepted |
| wr_valid | input | 1 | Host byte present |
| wr_data | input | 8 | Host byte |
| wr_ready | output | 1 | Buffer has room |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_done | output | 1 | Frame finished (one-cycle pulse) |
| tx_underrun | output | 1 | Frame abandoned on empty buffer |

## Verification
The hardest situation to reach from the ports is the start gate at the large thresholds. Showing that a frame of more than 1021 bytes starts within two cycles of the 1021st byte needs a host that writes slowly enough for the gate to matter, and the same frame must still finish without an underrun. The bench preloads a random number of bytes, issues the command, and then streams the remaining bytes one per cycle. This makes the start cycle predictable relative to the accepted-byte count. Underrun is provoked by cutting the write stream short after an early start.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_PRE, S_DATA, S_PAD, S_FCS
  } fr_state_t;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  // start threshold in bytes for selects 0..2; select 3 means whole frame
  function automatic logic [15:0] start_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16'd5;
      2'd1:    return 16'd381;
      2'd2:    return 16'd1021;
      default: return 16'hFFFF;
    endcase
  endfunction

  // minimum body size when padding is on
  function automatic logic [15:0] pad_floor(input logic crc_on);
    return crc_on ? 16'd60 : 16'd64;
  endfunction

  // reflected CRC-32 step over one byte, LSB first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // byte k of the transmitted check sequence
  function automatic logic [7:0] fcs_byte(input logic [31:0] c, input logic [1:0] k);
    logic [31:0] f;
    f = ~c;
    return f[8*k +: 8];
  endfunction

endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [7:0]   din,
  input  logic         pop,
  output logic [7:0]   dout,
  output logic [AW:0]  level,
  output logic         full,
  output logic         empty
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/tx_crc32.sv
module tx_crc32 import tx_framer_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc <= 32'hFFFFFFFF;
    else if (en)         crc <= crc32_byte(crc, din);
  end
endmodule

// File: rtl/tx_framer.sv
module tx_framer import tx_framer_pkg::*; #(
  parameter int DEPTH = 2048,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_start_sel,
  input  logic             cmd_pad_en,
  input  logic             cmd_crc_en,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             cmd_ready,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             tx_done,
  output logic             tx_underrun
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  fr_state_t        state_q, nxt_state;
  logic [LEN_W-1:0] cnt_q, nxt_cnt;
  logic [LEN_W-1:0] len_q, body_q, thr_q;
  logic             crc_on_q;

  // internal events, brought out by name for the checker
  logic             accept, start_evt, under_evt, pop, emit, last;
  logic             crc_clr, crc_en, under_q;
  logic [7:0]       byte_out;

  logic [7:0]       fifo_dout;
  logic [LVL_W-1:0] level;
  logic             full, empty;
  logic [31:0]      crc;

  tx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_valid), .din(wr_data), .pop(pop),
    .dout(fifo_dout), .level(level), .full(full), .empty(empty)
  );

  tx_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en), .din(byte_out), .crc(crc)
  );

  assign cmd_ready = (state_q == S_IDLE);
  assign wr_ready  = !full;

  // effective threshold and body size for a command
  logic [15:0] thr_raw, floor_raw;
  assign thr_raw   = start_bytes(cmd_start_sel);
  assign floor_raw = pad_floor(cmd_crc_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0; body_q <= '0; thr_q <= '0; crc_on_q <= 1'b0;
    end else if (accept) begin
      len_q    <= cmd_len;
      crc_on_q <= cmd_crc_en;
      thr_q    <= (32'(thr_raw) > 32'(cmd_len)) ? cmd_len : LEN_W'(thr_raw);
      body_q   <= (cmd_pad_en && 32'(cmd_len) < 32'(floor_raw)) ? LEN_W'(floor_raw) : cmd_len;
    end
  end

  always_comb begin
    nxt_state = state_q;  nxt_cnt = cnt_q;
    byte_out  = 8'h00;    emit = 1'b0;  last = 1'b0;  pop = 1'b0;
    crc_en    = 1'b0;     crc_clr = 1'b0;
    accept    = 1'b0;     start_evt = 1'b0;  under_evt = 1'b0;
    case (state_q)
      S_IDLE: if (cmd_valid) begin
        accept = 1'b1; nxt_state = S_WAIT;
      end
      S_WAIT: if (32'(level) >= 32'(thr_q)) begin
        start_evt = 1'b1; crc_clr = 1'b1; nxt_state = S_PRE; nxt_cnt = '0;
      end
      S_PRE: begin
        emit = 1'b1;
        byte_out = (cnt_q == LEN_W'(7)) ? SFD_BYTE : PRE_BYTE;
        if (cnt_q == LEN_W'(7)) begin nxt_state = S_DATA; nxt_cnt = '0; end
        else nxt_cnt = cnt_q + LEN_W'(1);
      end
      S_DATA: begin
        if (empty) begin
          under_evt = 1'b1; nxt_state = S_IDLE;
        end else begin
          emit = 1'b1; byte_out = fifo_dout; pop = 1'b1; crc_en = 1'b1;
          nxt_cnt = cnt_q + LEN_W'(1);
          if (cnt_q + LEN_W'(1) == len_q) begin
            if (body_q != len_q)  nxt_state = S_PAD;
            else if (crc_on_q) begin nxt_state = S_FCS; nxt_cnt = '0; end
            else begin last = 1'b1; nxt_state = S_IDLE; end
          end
        end
      end
      S_PAD: begin
        emit = 1'b1; crc_en = 1'b1;
        nxt_cnt = cnt_q + LEN_W'(1);
        if (cnt_q + LEN_W'(1) == body_q) begin
          if (crc_on_q) begin nxt_state = S_FCS; nxt_cnt = '0; end
          else begin last = 1'b1; nxt_state = S_IDLE; end
        end
      end
      S_FCS: begin
        emit = 1'b1; byte_out = fcs_byte(crc, cnt_q[1:0]);
        if (cnt_q == LEN_W'(3)) begin last = 1'b1; nxt_state = S_IDLE; end
        else nxt_cnt = cnt_q + LEN_W'(1);
      end
      default: nxt_state = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE; cnt_q <= '0; under_q <= 1'b0;
      tx_valid <= 1'b0; tx_data <= 8'h00; tx_last <= 1'b0;
      tx_done <= 1'b0; tx_underrun <= 1'b0;
    end else begin
      state_q     <= nxt_state;
      cnt_q       <= nxt_cnt;
      under_q     <= under_evt;
      tx_valid    <= emit;
      tx_data     <= byte_out;
      tx_last     <= last;
      tx_underrun <= under_q;
      tx_done     <= (tx_valid && tx_last) || under_q;
    end
  end
endmodule

// File: rtl/tx_framer_sva.sv
module tx_framer_sva #(
  parameter int LEN_W = 11,
  parameter int LVL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_last,
  input logic             tx_done,
  input logic             tx_underrun,
  input logic             start_evt,
  input logic             pop,
  input logic [LVL_W-1:0] level,
  input logic [LEN_W-1:0] thr_q
);
  // R9: last flag only on a valid byte
  a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R9: done follows the final byte by one cycle
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last) |=> tx_done);

  // R8: underrun is reported together with done
  a_r8_underrun_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> tx_done);

  // R8: no byte is presented in the underrun cycle
  a_r8_underrun_silent: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> !tx_valid);

  // R2: sequencer leaves the wait state only with enough buffered bytes
  a_r2_threshold_met: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> 32'(level) >= 32'(thr_q));

  // R4: the buffer is never read while empty
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level != '0);
endmodule

bind tx_framer tx_framer_sva #(.LEN_W(LEN_W), .LVL_W(LVL_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_last(tx_last),
  .tx_done(tx_done), .tx_underrun(tx_underrun), .start_evt(start_evt),
  .pop(pop), .level(level), .thr_q(thr_q)
);

// File: tb/tx_framer_test.sv
module tx_framer_test;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_start_sel = 2'd0;
  logic cmd_pad_en = 1'b0, cmd_crc_en = 1'b0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic cmd_ready, wr_ready;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_valid, tx_last, tx_done, tx_underrun;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  tx_framer #(.DEPTH(2048), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_start_sel(cmd_start_sel),
    .cmd_pad_en(cmd_pad_en), .cmd_crc_en(cmd_crc_en), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_done(tx_done), .tx_underrun(tx_underrun)
  );

  int checks = 0, fails = 0, cyc = 0, wr_cnt = 0;
  logic [7:0] host [0:2047];
  logic [7:0] fb   [0:2047];
  logic [7:0] cap  [0:2199];
  int cap_n, first_wr, first_cyc, end_cyc, last_n, last_at, last_cyc, done_n, done_cyc, und_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (wr_valid && wr_ready) wr_cnt++;
    if (cyc == 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (tx_valid) begin
      if (cap_n == 0) begin first_wr = wr_cnt; first_cyc = cyc; end
      if (cap_n < 2200) cap[cap_n] = tx_data;
      if (tx_last) begin last_n++; last_at = cap_n; last_cyc = cyc; end
      cap_n++; end_cyc = cyc;
    end
    if (tx_done) begin done_n++; done_cyc = cyc; end
    if (tx_underrun) und_n++;
  end

  // CRC-32, MSB-first form over bit-reversed input, reflected at the end
  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c, r;
    logic fbk;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        fbk = c[31] ^ fb[i][b];
        c = {c[30:0], 1'b0};
        if (fbk) c = c ^ 32'h04C11DB7;
      end
    for (int b = 0; b < 32; b++) r[b] = c[31-b];
    return ~r;
  endfunction

  function automatic int thr_of(input int sel, input int len);
    int t;
    t = (sel == 0) ? 5 : (sel == 1) ? 381 : (sel == 2) ? 1021 : len;
    return (t > len) ? len : t;
  endfunction

  task automatic put_bytes(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_data = host[i];
      @(posedge clk);
      while (!wr_ready) @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_frame(input int sel, input bit pad, input bit crc, input int len,
                           input int pre, input int stop, input bit bogus);
    int thr, body, total, mism_data, mism_pad, mism_fcs, w;
    logic [31:0] fcs;
    for (int i = 0; i < len; i++) host[i] = 8'($urandom);
    @(negedge clk);
    cap_n = 0; last_n = 0; done_n = 0; und_n = 0; wr_cnt = 0;
    first_wr = -1; last_at = -1; last_cyc = 0; done_cyc = 0;
    thr  = thr_of(sel, len);
    body = (pad && len < (crc ? 60 : 64)) ? (crc ? 60 : 64) : len;
    for (int i = 0; i < body; i++) fb[i] = (i < len) ? host[i] : 8'h00;
    fcs  = ref_fcs(body);
    total = 8 + body + (crc ? 4 : 0);
    if (pre > 0) put_bytes(0, pre);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 ready before command", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_start_sel = 2'(sel); cmd_pad_en = pad; cmd_crc_en = crc;
    cmd_len = LEN_W'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    put_bytes(pre, stop);
    if (bogus) begin
      cmd_valid = 1'b1; cmd_start_sel = 2'd0; cmd_len = LEN_W'(3);
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    w = 0;
    while (done_n == 0 && w < 4000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);

    chk(first_wr >= thr, "R2 start after threshold", first_wr, thr);
    if (pre < thr && stop == len)
      chk(first_wr <= ((thr + 2 > len) ? len : thr + 2), "R2 start not late", first_wr, thr + 2);
    for (int i = 0; i < 8; i++)
      if (cap[i] != ((i == 7) ? 8'hD5 : 8'h55))
        chk(1'b0, "R3 preamble byte", int'(cap[i]), (i == 7) ? 8'hD5 : 8'h55);
    checks++;
    if (stop < len) begin
      mism_data = 0;
      for (int i = 0; i < stop; i++) if (cap[8+i] != host[i]) mism_data++;
      chk(mism_data == 0, "R8 bytes before underrun", mism_data, 0);
      chk(cap_n == 8 + stop, "R8 no bytes after underrun", cap_n, 8 + stop);
      chk(und_n == 1 && done_n == 1, "R8 underrun with done", und_n, 1);
      chk(last_n == 0, "R8 no last flag", last_n, 0);
      return;
    end
    mism_data = 0; mism_pad = 0; mism_fcs = 0;
    for (int i = 0; i < len; i++) if (cap[8+i] != host[i]) mism_data++;
    for (int i = len; i < body; i++) if (cap[8+i] != 8'h00) mism_pad++;
    if (crc)
      for (int k = 0; k < 4; k++) if (cap[8+body+k] != fcs[8*k +: 8]) mism_fcs++;
    chk(mism_data == 0, "R4 host bytes", mism_data, 0);
    chk(mism_pad == 0, "R5 pad bytes", mism_pad, 0);
    chk(cap_n == total, crc ? "R6 frame length" : "R7 frame length", cap_n, total);
    if (crc) chk(mism_fcs == 0, "R6 check sequence", mism_fcs, 0);
    chk(last_n == 1 && last_at == total - 1, "R9 last on final byte", last_at, total - 1);
    chk(end_cyc - first_cyc == total - 1, "R9 contiguous bytes", end_cyc - first_cyc, total - 1);
    chk(done_n == 1 && done_cyc == last_cyc + 1, "R9 done timing", done_cyc, last_cyc + 1);
    chk(und_n == 0, "R8 no spurious underrun", und_n, 0);
    if (bogus) begin
      cap_n = 0;
      repeat (40) @(negedge clk);
      chk(cap_n == 0, "R10 busy command ignored", cap_n, 0);
      chk(cmd_ready == 1'b1, "R10 idle after frame", int'(cmd_ready), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cap_n = 0; last_n = 0; done_n = 0; und_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !tx_last && !tx_done && !tx_underrun, "R1 outputs idle",
        int'({tx_valid, tx_last, tx_done, tx_underrun}), 0);
    chk(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);

    run_frame(0, 1, 1, 100, 0, 100, 0);   // R4 R6 plain frame
    run_frame(0, 1, 1, 20, 0, 20, 0);     // R5 pad to 60
    run_frame(0, 1, 0, 20, 0, 20, 0);     // R5 pad to 64, R7
    run_frame(0, 0, 1, 20, 0, 20, 0);     // R5 no pad when off
    run_frame(0, 1, 1, 59, 0, 59, 0);     // R5 one pad byte
    run_frame(0, 1, 1, 60, 0, 60, 0);     // R5 boundary, no pad
    run_frame(1, 0, 1, 600, 0, 600, 0);   // R2 381
    run_frame(2, 1, 1, 1100, 0, 1100, 0); // R2 1021
    run_frame(2, 0, 0, 500, 0, 500, 0);   // R2 1021 cut to length
    run_frame(3, 0, 1, 300, 0, 300, 0);   // R2 whole frame
    run_frame(3, 1, 1, 200, 200, 200, 0); // R2 whole frame preloaded
    run_frame(0, 1, 1, 1, 0, 1, 0);       // single host byte
    run_frame(0, 0, 1, 50, 0, 12, 0);     // R8 underrun
    run_frame(0, 1, 1, 120, 0, 120, 1);   // R10 busy command
    for (int n = 0; n < 10; n++) begin
      int len, pre;
      len = 1 + int'($urandom % 1200);
      pre = int'($urandom % (len + 1));
      run_frame(int'($urandom % 4), 1'($urandom), 1'($urandom), len, pre, len, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule